// File: doc/BRIEF.md
# Echo-Polled Status Bit Receiver

This block fetches a single pass/fail bit from a remote target once a download step has finished. A controller pulses a request and picks one of two timeout lengths. In echo mode the block then offers a fixed probe byte to a UART transmitter at a steady millisecond pace. It waits for the target to send back a byte that carries the answer. The answer byte is the base value 0xFE plus the status bit. Any other byte means the link has lost step with the target. If no byte arrives in time, the result is also a lost target.

The same block serves every result check of a load sequence: the RAM checksum, the non-volatile programming step and the verify step. The short limit fits the quick checks and the long limit fits programming. A non-echo mode sends no probes and only waits for a byte, which suits a handshake phase. Inputs are a millisecond tick, the UART's received byte with its strobe, and the transmitter's ready flag. The UART itself sits outside this block.

Top module: `status_bit_poller`

## Requirements
- R1: While reset is held and on the first cycle after it, tx_valid, done, res_bit and lost are all 0.
- R2: In echo mode (req_echo=1), the cycle after a request is accepted tx_valid rises with tx_byte equal to PROBE_CODE (default 0xF9). tx_valid stays high until a cycle with tx_ready=1 takes the probe.
- R3: After each probe is taken, the next probe is offered after PROBE_MS further ms_tick pulses (default 25). Ticks only count while no probe is pending.
- R4: While busy, a received byte of 0xFE or 0xFF ends the request. One cycle later done pulses with lost=0 and res_bit equal to the received byte minus 0xFE, so 0xFF gives res_bit=1, meaning the step failed.
- R5: While busy, any other received byte ends the request. One cycle later done pulses with lost=1 and res_bit=0.
- R6: If no byte arrives, done pulses with lost=1 one cycle after the tick that brings the ticks since acceptance to the limit. The limit is SHORT_MS (default 2500) when req_long=0 and LONG_MS (default 5000) when req_long=1. Probes never restart this count.
- R7: In non-echo mode (req_echo=0) tx_valid never rises. Received bytes are decoded as in R4 and R5.
- R8: done is high for exactly one cycle per request. res_bit and lost then hold until the next accepted request, which clears both to 0.
- R9: A request made while busy is ignored and does not restart the timeout. A byte received while idle is ignored and changes no output.
- R10: When a byte and the expiring tick arrive in the same cycle, the byte decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start pulse, accepted only when idle |
| req_echo | input | 1 | 1 = send probes, 0 = wait only |
| req_long | input | 1 | 1 = long timeout, 0 = short timeout |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | Probe byte offered |
| tx_byte | output | 8 | Probe byte value |
| done | output | 1 | One-cycle end-of-request pulse |
| res_bit | output | 1 | Recovered status bit (1 = step failed) |
| lost | output | 1 | Target lost: bad byte or timeout |

## Verification
The assertions check the following on every cycle: the probe value and how it is held until taken, the silence of non-echo mode and of the idle state, the decoding of good and bad bytes, that a timeout ends as lost, the single-cycle done pulse, and that results stay frozen while idle. Only the bench scenarios can show the exact tick at which each limit expires. They also show the probe pacing counted across a whole request, that a probe never restarts the timeout, that a request made while busy is ignored, and that a byte wins a tie with the expiring tick. The bench sweeps all 256 byte values through the decoder and runs both limits in both modes.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam logic [7:0] ANSWER_BASE = 8'hFE;

  // offset of a received byte from the answer base (wraps mod 256)
  function automatic logic [7:0] answer_offset(input logic [7:0] b);
    return b - ANSWER_BASE;
  endfunction

  // a byte is a valid answer when its offset is 0 or 1
  function automatic logic is_answer(input logic [7:0] b);
    return answer_offset(b) <= 8'd1;
  endfunction

  function automatic logic answer_bit(input logic [7:0] b);
    logic [7:0] d;
    d = answer_offset(b);
    return d[0];
  endfunction
endpackage

// File: rtl/sbp_timeout.sv
module sbp_timeout #(
  parameter int SHORT_MS = 2500,
  parameter int LONG_MS  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_long,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LONG_MS + 1);

  logic [CW-1:0] elapsed;
  logic [CW-1:0] limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      limit   <= CW'(SHORT_MS);
    end else if (start) begin
      elapsed <= '0;
      limit   <= sel_long ? CW'(LONG_MS) : CW'(SHORT_MS);
    end else if (run && tick) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = run && tick && (elapsed == limit - 1'b1);
endmodule

// File: rtl/sbp_probe_pacer.sv
module sbp_probe_pacer #(
  parameter int PROBE_MS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic echo_mode,
  input  logic run,
  input  logic tick,
  input  logic fire,
  output logic pending,
  output logic echo_q
);
  localparam int IW = (PROBE_MS < 2) ? 1 : $clog2(PROBE_MS + 1);

  logic [IW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      echo_q  <= 1'b0;
      gap     <= '0;
    end else if (start) begin
      echo_q  <= echo_mode;
      pending <= echo_mode;
      gap     <= '0;
    end else if (!run) begin
      pending <= 1'b0;
    end else if (fire) begin
      pending <= 1'b0;
      gap     <= '0;
    end else if (tick && echo_q && !pending) begin
      if (gap == IW'(PROBE_MS - 1)) begin
        pending <= 1'b1;
        gap     <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/status_bit_poller.sv
module status_bit_poller #(
  parameter int         SHORT_MS   = 2500,
  parameter int         LONG_MS    = 5000,
  parameter int         PROBE_MS   = 25,
  parameter logic [7:0] PROBE_CODE = 8'hF9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_echo,
  input  logic       req_long,
  input  logic       ms_tick,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       done,
  output logic       res_bit,
  output logic       lost
);
  import sbp_pkg::*;

  // named internal events, also observed by the bound checker
  logic busy_w;
  logic accept_w;
  logic rx_take_w;
  logic tmo_w;
  logic fire_w;
  logic pending_w;
  logic echo_w;

  assign accept_w  = req && !busy_w;
  assign rx_take_w = busy_w && rx_valid;
  assign tx_valid  = busy_w && pending_w;
  assign tx_byte   = PROBE_CODE;
  assign fire_w    = tx_valid && tx_ready;

  sbp_timeout #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept_w),
    .sel_long (req_long),
    .run      (busy_w),
    .tick     (ms_tick),
    .expired  (tmo_w)
  );

  sbp_probe_pacer #(.PROBE_MS(PROBE_MS)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_w),
    .echo_mode (req_echo),
    .run       (busy_w),
    .tick      (ms_tick),
    .fire      (fire_w),
    .pending   (pending_w),
    .echo_q    (echo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_w  <= 1'b0;
      done    <= 1'b0;
      res_bit <= 1'b0;
      lost    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept_w) begin
        busy_w  <= 1'b1;
        res_bit <= 1'b0;
        lost    <= 1'b0;
      end else if (rx_take_w) begin
        busy_w  <= 1'b0;
        done    <= 1'b1;
        res_bit <= is_answer(rx_byte) ? answer_bit(rx_byte) : 1'b0;
        lost    <= !is_answer(rx_byte);
      end else if (tmo_w) begin
        busy_w  <= 1'b0;
        done    <= 1'b1;
        res_bit <= 1'b0;
        lost    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter logic [7:0] PROBE_CODE = 8'hF9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       done,
  input logic       res_bit,
  input logic       lost,
  input logic       busy_w,
  input logic       echo_w,
  input logic       tmo_w
);
  AST_PROBE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_byte == PROBE_CODE); // R2
  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_valid && !tmo_w) |=> tx_valid); // R2
  AST_NOECHO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !echo_w) |-> !tx_valid); // R7
  AST_GOOD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && rx_valid && (rx_byte == 8'hFE || rx_byte == 8'hFF))
      |=> done && !lost && (res_bit == $past(rx_byte[0]))); // R4
  AST_BAD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && rx_valid && rx_byte != 8'hFE && rx_byte != 8'hFF)
      |=> done && lost && !res_bit); // R5
  AST_TMO_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !rx_valid && tmo_w) |=> done && lost); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !req) |=> $stable(res_bit) && $stable(lost) && !done); // R9
  AST_IDLE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !tx_valid); // R9
endmodule

bind status_bit_poller sbp_checker #(.PROBE_CODE(PROBE_CODE)) u_sbp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .rx_valid (rx_valid),
  .rx_byte  (rx_byte),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_byte  (tx_byte),
  .done     (done),
  .res_bit  (res_bit),
  .lost     (lost),
  .busy_w   (busy_w),
  .echo_w   (echo_w),
  .tmo_w    (tmo_w)
);

// File: tb/status_bit_poller_tb.sv
module status_bit_poller_tb;
  localparam int SHORT = 5;
  localparam int LONG  = 9;
  localparam int PACE  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, req_echo = 0, req_long = 0, ms_tick = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_valid, done, res_bit, lost;
  logic [7:0] tx_byte;

  int total = 0;
  int bad = 0;
  int probes = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  status_bit_poller #(.SHORT_MS(SHORT), .LONG_MS(LONG), .PROBE_MS(PACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_echo(req_echo), .req_long(req_long),
    .ms_tick(ms_tick), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .done(done), .res_bit(res_bit), .lost(lost)
  );

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) probes <= probes + 1;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic echo, input logic lng);
    req = 1; req_echo = echo; req_long = lng;
    @(negedge clk);
    req = 0; req_echo = 0; req_long = 0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic give_tick();
    ms_tick = 1;
    @(negedge clk);
    ms_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tx_valid in reset", tx_valid, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 res_bit after reset", res_bit, 0);
    check("R1 lost after reset", lost, 0);

    // R4 R5 R7: every byte value, non-echo mode
    for (int b = 0; b < 256; b++) begin
      int p0;
      int off;
      int exp_lost;
      int exp_res;
      off = (b + 2) % 256;
      exp_lost = (off <= 1) ? 0 : 1;
      exp_res  = (off == 1) ? 1 : 0;
      p0 = probes;
      do_req(0, 0);
      send_rx(8'(b));
      check($sformatf("R4/R5 done byte %0h", b), done, 1);
      check($sformatf("R4/R5 lost byte %0h", b), lost, exp_lost);
      check($sformatf("R4 res_bit byte %0h", b), res_bit, exp_res);
      check("R7 no probe in wait mode", probes, p0);
      @(negedge clk);
      check("R8 done single cycle", done, 0);
      check("R8 lost held", lost, exp_lost);
    end

    // R2 R3: probe offer, hold and pacing
    tx_ready = 0;
    do_req(1, 0);
    check("R2 probe offered", tx_valid, 1);
    check("R2 probe code", tx_byte, 8'hF9);
    repeat (3) @(negedge clk);
    check("R2 probe held without ready", tx_valid, 1);
    begin
      int p0;
      p0 = probes;
      tx_ready = 1;
      @(negedge clk);
      tx_ready = 0;
      check("R2 probe taken once", probes - p0, 1);
      check("R2 offer drops after take", tx_valid, 0);
    end
    for (int k = 1; k < PACE; k++) begin
      give_tick();
      check("R3 no probe before pace", tx_valid, 0);
    end
    give_tick();
    check("R3 probe after pace", tx_valid, 1);
    send_rx(8'hFE);
    check("R4 pass answer done", done, 1);
    check("R4 pass answer lost", lost, 0);

    // R6 R3: timeout limits in both modes
    tx_ready = 1;
    for (int sl = 0; sl < 2; sl++) begin
      for (int ec = 0; ec < 2; ec++) begin
        int lim;
        int p0;
        int exp_probes;
        lim = sl ? LONG : SHORT;
        exp_probes = ec ? 1 + (lim - 1) / PACE : 0;
        p0 = probes;
        do_req(ec[0], sl[0]);
        @(negedge clk);
        for (int k = 1; k <= lim; k++) begin
          give_tick();
          if (k < lim) check($sformatf("R6 no end at tick %0d", k), done, 0);
          else begin
            check($sformatf("R6 end at limit %0d", lim), done, 1);
            check("R6 timeout lost", lost, 1);
          end
          @(negedge clk);
        end
        check($sformatf("R3 probe count lim %0d echo %0d", lim, ec), probes - p0, exp_probes);
      end
    end
    tx_ready = 0;

    // R9: request while busy ignored
    do_req(0, 0);
    give_tick();
    give_tick();
    do_req(1, 1);
    give_tick();
    give_tick();
    check("R9 busy req no end", done, 0);
    check("R9 busy req kept wait mode", tx_valid, 0);
    give_tick();
    check("R9 original limit kept", done, 1);
    check("R9 original limit lost", lost, 1);
    @(negedge clk);
    send_rx(8'hFE);
    check("R9 idle byte no done", done, 0);
    check("R9 idle byte lost kept", lost, 1);
    check("R9 idle byte res kept", res_bit, 0);

    // R8: new request clears results
    do_req(0, 0);
    check("R8 lost cleared on accept", lost, 0);
    send_rx(8'hFF);
    check("R4 fail answer res", res_bit, 1);
    check("R4 fail answer lost", lost, 0);
    @(negedge clk);
    do_req(0, 0);
    check("R8 res cleared on accept", res_bit, 0);

    // R10: byte beats expiring tick
    for (int k = 1; k < SHORT; k++) give_tick();
    check("R10 not yet expired", done, 0);
    ms_tick = 1;
    send_rx(8'hFF);
    ms_tick = 0;
    check("R10 tie done", done, 1);
    check("R10 tie lost", lost, 0);
    check("R10 tie res", res_bit, 1);
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule